// File: doc/BRIEF.md
# Valid-Sample Temperature Averaging Filter

This block smooths a stream of processor temperature readings. Each sample strobe brings in a 16-bit relative reading and a flag that says whether fetching that reading worked. A good reading is converted to Kelvin against a junction-maximum constant. A failed fetch is recorded as an unusable entry. The result goes into the next slot of a small ring that wraps around. The ring starts out holding 300 K in every slot, and every slot is marked usable.

A read request returns the mean of the usable slots, rounded down. The answer is refused when fewer than two slots are usable, so that one spurious reading cannot set off a thermal trip. When the power-good input is low, the request is answered at once with a not-powered code and nothing is computed. The division is done bit-serially. A one-cycle done pulse presents the temperature and the status code together.

Top module: `temp_avg_filter`

## Requirements
- R1: After reset the ring holds DEPTH slots, each 300 K and each usable. The outputs read temperature 0, status 0 and done low. A first powered read returns 300 with status 0 (OK).
- R2: A usable sample raw r is stored as the Kelvin value k. Here n = (~r + 1) mod 2^16, and k = (tjmax + 273 - (n >> 6)) mod 2^TEMP_W.
- R3: A sample strobed with the raw-valid flag low marks its slot unusable. That slot adds to neither the sum nor the count.
- R4: If fewer than two slots are usable, done comes with status 2 (too few) and temperature 0.
- R5: With two or more usable slots, the result is the floor of their sum divided by their count, with status 0.
- R6: A read request taken while power-good is low is answered with status 1 (not powered) and temperature 0.
- R7: Writes go to slots 0,1,...,DEPTH-1 and then wrap back to slot 0. Each strobe replaces the oldest entry.
- R8: When a sample strobe and a read request come in the same cycle, the read includes the new sample.
- R9: The block gives exactly one done pulse, one cycle long, for each request it accepts. A request made while a previous one is still in progress is ignored. The temperature output changes only when done is high.
- R10: Done is asserted no more than TEMP_W + log2(DEPTH) + 3 cycles after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe; writes the next ring slot |
| raw_i | input | RAW_W | Raw relative temperature reading |
| raw_ok_i | input | 1 | High when the fetch of raw_i succeeded |
| tjmax_i | input | TJ_W | Junction-maximum constant in degrees C |
| pwr_good_i | input | 1 | High while the monitored domain is powered |
| read_req_i | input | 1 | Request for a filtered reading |
| temp_o | output | TEMP_W | Filtered temperature in Kelvin, 0 on error |
| status_o | output | 2 | 0 OK, 1 not powered, 2 too few usable slots |
| done_o | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench builds the block with its defaults: a depth of 4, 16-bit readings and results, and an 8-bit junction maximum. At this depth all 16 patterns of usable and unusable slots can be swept, so every count from zero to four is reached, including the refusal at zero and at one. A separate sweep puts 1024 raw values through the conversion, covering the whole range of the shifted negation. Along the way it produces Kelvin values that wrap, and averages whose remainders are not zero, which exercise every step of the serial divider.

// File: rtl/temp_filt_pkg.sv
package temp_filt_pkg;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NO_POWER = 2'd1,
    ST_TOO_FEW  = 2'd2
  } tf_status_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_PWR  = 2'd1,
    F_SUM  = 2'd2,
    F_DIV  = 2'd3
  } tf_state_e;

endpackage

// File: rtl/temp_convert.sv
module temp_convert #(
  parameter int RAW_W     = 16,
  parameter int TEMP_W    = 16,
  parameter int TJ_W      = 8,
  parameter int FRAC_BITS = 6,
  parameter int K_OFFSET  = 273
) (
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [TJ_W-1:0]   tjmax_i,
  output logic [TEMP_W-1:0] kelvin_o
);
  logic [RAW_W-1:0] neg;
  logic [RAW_W-1:0] below_max;

  always_comb begin
    neg       = ~raw_i + RAW_W'(1);
    below_max = neg >> FRAC_BITS;
    kelvin_o  = TEMP_W'(tjmax_i) + TEMP_W'(K_OFFSET) - TEMP_W'(below_max);
  end
endmodule

// File: rtl/sample_ring.sv
module sample_ring #(
  parameter int DEPTH   = 4,
  parameter int TEMP_W  = 16,
  parameter int RESET_K = 300
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [TEMP_W-1:0]             wr_val_i,
  input  logic                          wr_ok_i,
  output logic [DEPTH-1:0][TEMP_W-1:0]  vals_o,
  output logic [DEPTH-1:0]              oks_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] wr_idx;

  // power-of-two depth: index wraps by natural overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wr_idx <= '0;
    else if (wr_i) wr_idx <= wr_idx + IDX_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vals_o[g] <= TEMP_W'(RESET_K);
        oks_o[g]  <= 1'b1;
      end else if (wr_i && (wr_idx == IDX_W'(g))) begin
        vals_o[g] <= wr_val_i;
        oks_o[g]  <= wr_ok_i;
      end
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int N_W = 18,
  parameter int D_W = 3,
  parameter int Q_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic [Q_W-1:0] quo_o,
  output logic           done_o
);
  localparam int C_W = $clog2(N_W + 1);

  logic [N_W-1:0] sh;
  logic [D_W-1:0] rem;
  logic [D_W-1:0] den;
  logic [C_W-1:0] left;
  logic           run;
  logic [D_W:0]   trial;
  logic           fits;

  always_comb begin
    trial = {rem, sh[N_W-1]};
    fits  = (trial >= {1'b0, den});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '0;
      rem    <= '0;
      den    <= '0;
      left   <= '0;
      run    <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        sh   <= num_i;
        rem  <= '0;
        den  <= den_i;
        left <= C_W'(N_W);
        run  <= 1'b1;
      end else if (run) begin
        // restoring step: quotient bits shift in behind the dividend
        rem  <= fits ? D_W'(trial - {1'b0, den}) : D_W'(trial);
        sh   <= {sh[N_W-2:0], fits};
        left <= left - C_W'(1);
        if (left == C_W'(1)) begin
          run    <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = sh[Q_W-1:0];
endmodule

// File: rtl/temp_avg_filter.sv
module temp_avg_filter
  import temp_filt_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int RAW_W     = 16,
  parameter int TEMP_W    = 16,
  parameter int TJ_W      = 8,
  parameter int FRAC_BITS = 6,
  parameter int RESET_K   = 300,
  parameter int K_OFFSET  = 273
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [RAW_W-1:0]  raw_i,
  input  logic              raw_ok_i,
  input  logic [TJ_W-1:0]   tjmax_i,
  input  logic              pwr_good_i,
  input  logic              read_req_i,
  output logic [TEMP_W-1:0] temp_o,
  output logic [1:0]        status_o,
  output logic              done_o
);
  localparam int SUM_W = TEMP_W + ((DEPTH > 1) ? $clog2(DEPTH) : 1);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TEMP_W-1:0]            conv_k;
  logic [DEPTH-1:0][TEMP_W-1:0] vals;
  logic [DEPTH-1:0]             oks;
  logic [SUM_W-1:0]             sum;
  logic [CNT_W-1:0]             cnt;
  logic                         enough;
  logic                         div_start;
  logic                         div_done;
  logic [TEMP_W-1:0]            quo;
  tf_state_e                    state;

  temp_convert #(
    .RAW_W(RAW_W), .TEMP_W(TEMP_W), .TJ_W(TJ_W),
    .FRAC_BITS(FRAC_BITS), .K_OFFSET(K_OFFSET)
  ) u_conv (
    .raw_i    (raw_i),
    .tjmax_i  (tjmax_i),
    .kelvin_o (conv_k)
  );

  sample_ring #(
    .DEPTH(DEPTH), .TEMP_W(TEMP_W), .RESET_K(RESET_K)
  ) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (sample_i),
    .wr_val_i (conv_k),
    .wr_ok_i  (raw_ok_i),
    .vals_o   (vals),
    .oks_o    (oks)
  );

  // sum/count read from ring one cycle after request: a same-cycle write is included
  always_comb begin
    sum = '0;
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (oks[i]) begin
        sum = sum + SUM_W'(vals[i]);
        cnt = cnt + CNT_W'(1);
      end
    end
    enough    = (cnt >= CNT_W'(2));
    div_start = (state == F_SUM) && enough;
  end

  seq_divider #(
    .N_W(SUM_W), .D_W(CNT_W), .Q_W(TEMP_W)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (sum),
    .den_i   (cnt),
    .quo_o   (quo),
    .done_o  (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= F_IDLE;
      temp_o   <= '0;
      status_o <= ST_OK;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        F_IDLE: if (read_req_i) state <= pwr_good_i ? F_SUM : F_PWR;
        F_PWR: begin
          temp_o   <= '0;
          status_o <= ST_NO_POWER;
          done_o   <= 1'b1;
          state    <= F_IDLE;
        end
        F_SUM: begin
          if (!enough) begin
            temp_o   <= '0;
            status_o <= ST_TOO_FEW;
            done_o   <= 1'b1;
            state    <= F_IDLE;
          end else begin
            state <= F_DIV;
          end
        end
        F_DIV: begin
          if (div_done) begin
            temp_o   <= quo;
            status_o <= ST_OK;
            done_o   <= 1'b1;
            state    <= F_IDLE;
          end
        end
        default: state <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/temp_avg_filter_chk.sv
module temp_avg_filter_chk #(
  parameter int DEPTH  = 4,
  parameter int TEMP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              read_req_i,
  input logic [TEMP_W-1:0] temp_o,
  input logic [1:0]        status_o,
  input logic              done_o
);
  localparam int SUM_W = TEMP_W + ((DEPTH > 1) ? $clog2(DEPTH) : 1);
  localparam int LIMIT = SUM_W + 3;

  logic        pend;
  logic [15:0] wait_cnt;

  // independent model of request acceptance and wait time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend     <= 1'b0;
      wait_cnt <= '0;
    end else if (done_o) begin
      pend     <= read_req_i;
      wait_cnt <= '0;
    end else if (!pend) begin
      pend     <= read_req_i;
      wait_cnt <= '0;
    end else begin
      wait_cnt <= wait_cnt + 16'd1;
    end
  end

  assert_done_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pend);

  assert_temp_moves_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(temp_o) |-> done_o);

  assert_latency_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> (wait_cnt <= 16'(LIMIT)));

  assert_error_zero_temp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o != 2'd0) |-> (temp_o == '0));

  assert_legal_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 2'd3));
endmodule

bind temp_avg_filter temp_avg_filter_chk #(.DEPTH(DEPTH), .TEMP_W(TEMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .read_req_i (read_req_i),
  .temp_o     (temp_o),
  .status_o   (status_o),
  .done_o     (done_o)
);

// File: tb/tb_temp_avg_filter.sv
module tb_temp_avg_filter;
  localparam int DEPTH = 4;
  localparam int LAT_MAX = 16 + 2 + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample = 1'b0;
  logic [15:0] raw = '0;
  logic        raw_ok = 1'b0;
  logic [7:0]  tjmax = 8'd100;
  logic        pg = 1'b1;
  logic        req = 1'b0;
  logic [15:0] temp;
  logic [1:0]  status;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] m_val [DEPTH];
  bit          m_ok  [DEPTH];
  int          m_idx;

  always #4 clk = ~clk;

  temp_avg_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .raw_i(raw),
    .raw_ok_i(raw_ok), .tjmax_i(tjmax), .pwr_good_i(pg),
    .read_req_i(req), .temp_o(temp), .status_o(status), .done_o(done)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] to_k(input logic [15:0] r, input logic [7:0] tj);
    logic [15:0] n;
    n = (~r) + 16'd1;
    return 16'(tj) + 16'd273 - (n >> 6);
  endfunction

  function automatic void model_put(input logic [15:0] r, input bit ok);
    m_val[m_idx] = to_k(r, tjmax);
    m_ok[m_idx]  = ok;
    m_idx        = (m_idx + 1) % DEPTH;
  endfunction

  task automatic put(input logic [15:0] r, input bit ok);
    raw = r; raw_ok = ok; sample = 1'b1;
    model_put(r, ok);
    @(negedge clk);
    sample = 1'b0;
  endtask

  // issues a request (optionally with a same-cycle sample) and checks the answer
  task automatic do_read(input string rq, input bit with_s, input logic [15:0] r, input bit ok);
    int cnt, sum, lat, exp_t, exp_s;
    if (with_s) begin
      raw = r; raw_ok = ok; sample = 1'b1;
      model_put(r, ok);
    end
    cnt = 0; sum = 0;
    for (int i = 0; i < DEPTH; i++)
      if (m_ok[i]) begin cnt++; sum += int'(m_val[i]); end
    if (!pg)          begin exp_s = 1; exp_t = 0; end
    else if (cnt < 2) begin exp_s = 2; exp_t = 0; end
    else              begin exp_s = 0; exp_t = (sum / cnt) & 16'hFFFF; end
    req = 1'b1;
    @(negedge clk);
    req = 1'b0; sample = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    check(done == 1'b1, {rq, " done seen"}, int'(done), 1);
    check(lat <= LAT_MAX, "R10 latency", lat, LAT_MAX);
    check(status == 2'(exp_s), {rq, " status"}, int'(status), exp_s);
    check(temp == 16'(exp_t), {rq, " temp"}, int'(temp), exp_t);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_val[i] = 16'd300; m_ok[i] = 1'b1; end
    m_idx = 0;
    repeat (3) @(negedge clk);
    // R1: reset outputs
    check(temp == 16'd0, "R1 reset temp", int'(temp), 0);
    check(status == 2'd0, "R1 reset status", int'(status), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read("R1 preset 300 K", 1'b0, '0, 1'b0);

    // R3 R4 R5: every usable/unusable pattern over the full ring
    for (int m = 0; m < 16; m++) begin
      tjmax = 8'(90 + m);
      for (int s = 0; s < DEPTH; s++)
        put(16'((m * 977 + s * 4099) & 16'hFFFF) | 16'hC000, m[s]);
      do_read("R3 R4 R5 mask sweep", 1'b0, '0, 1'b0);
    end

    // R2: conversion across the shifted range
    tjmax = 8'd105;
    for (int i = 0; i < 1024; i++) begin
      put(16'((i << 6) | (i & 63)), 1'b1);
      do_read("R2 conversion", 1'b0, '0, 1'b0);
    end

    // R7: slot order and oldest-first replacement
    for (int s = 0; s < DEPTH; s++) put(16'hFF00, 1'b0);
    put(16'hFFC0, 1'b1);
    do_read("R7 one usable after wrap", 1'b0, '0, 1'b0);
    put(16'hF000, 1'b1);
    do_read("R7 two usable", 1'b0, '0, 1'b0);
    put(16'hFE00, 1'b1);
    put(16'hFC05, 1'b1);
    do_read("R7 ring full", 1'b0, '0, 1'b0);
    put(16'hFFFF, 1'b0);
    do_read("R7 oldest replaced", 1'b0, '0, 1'b0);

    // R6: not powered, then the same ring read powered
    pg = 1'b0;
    do_read("R6 not powered", 1'b0, '0, 1'b0);
    pg = 1'b1;
    do_read("R6 powered again", 1'b0, '0, 1'b0);

    // R8: same-cycle write then read
    do_read("R8 write before read", 1'b1, 16'hE000, 1'b1);
    do_read("R8 invalid write before read", 1'b1, 16'hD000, 1'b0);

    // R9: extra request while busy is ignored
    begin
      int dones;
      dones = 0;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (2) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      for (int c = 0; c < 50; c++) begin
        if (done) dones++;
        @(negedge clk);
      end
      check(dones == 1, "R9 busy request ignored", dones, 1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule